// File: doc/BRIEF.md
# SPI Serial Save-Memory Target

This block behaves as a small serial save-memory device on an SPI bus in mode 0 (clock idles low, data sampled on the rising edge, shifted on the falling edge). A host lowers chip select, sends one command byte, and then sends or receives parameter and data bytes. The store is an internal byte array. The supported commands are: set and clear a write-enable latch, read the status byte (repeated while selected), write the status byte, an identification query that always answers FFh, and memory read and write.

The parameter `ADDR9` selects the addressing scheme. With `ADDR9=1`, bit 3 of the opcode supplies address bit 8 and one low address byte follows. With `ADDR9=0`, two address bytes follow, high byte first, and only the low log2(`MEM_BYTES`) bits are used. Writes are first gathered in a page buffer. They are committed only when chip select rises on a byte boundary with the latch set. A commit starts a busy period of `BUSY_CYCLES` system clocks. The SPI pins are synchronised into `clk`, so each SCLK high and low phase must last at least 6 `clk` cycles. The pins are plain control signals: there is no valid/ready stream and no back-pressure, and the host paces every transfer.

Top module: `spibk_target`

## Requirements
- R1: After reset the status byte reads F0h in 9-bit mode and 00h in 16-bit mode. Bit 0 is busy, bit 1 is the write-enable latch, bits 3:2 are the protect field, bits 7:4 are all ones in 9-bit mode, bits 6:4 are zero in 16-bit mode, and bit 7 is the lock bit in 16-bit mode.
- R2: Opcode 06h sets the latch and opcode 04h clears it. Opcode 05h returns the current status byte in every following byte for as long as chip select stays low.
- R3: Opcode 9Fh answers with FFh in every following byte.
- R4: In 9-bit mode, opcodes 02h and 03h write and read locations 000h–0FFh, and opcodes 0Ah and 0Bh write and read locations 100h–1FFh. One low address byte follows the opcode.
- R5: In 16-bit mode, opcode 02h writes and opcode 03h reads. The address high byte and then the low byte follow the opcode.
- R6: A memory write or status write takes effect only if chip select rises after a whole number of bytes with the latch set. Otherwise memory and the latch are unchanged.
- R7: Write data bytes beyond the page size wrap to the start of the same page. A later byte replaces an earlier byte at the same location.
- R8: Read data auto-increments and wraps from the last array location to location 0.
- R9: A committed write clears the latch and holds status bit 0 at 1 for `BUSY_CYCLES` clocks. The bit is visible live in repeated status bytes.
- R10: While busy, every opcode other than 05h is ignored. A read returns FFh and a 06h opcode leaves the latch clear.
- R11: Opcode 01h with one data byte changes only bits 3:2, plus bit 7 in 16-bit mode, and clears the latch.
- R12: Protect field values 1, 2 and 3 discard written bytes in the upper quarter, the upper half and the whole array respectively. Unprotected bytes are still written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, MSB first |

## Verification
Two functions can overlap in time: the busy countdown ending, and a status read that keeps repeating across that moment. The bench commits a write and at once keeps chip select low through several status bytes. It expects the first byte to show busy and a byte well after the countdown to show idle, with the latch clear in both. The second overlap is a command arriving during the busy window. The bench issues a read and a latch-set while busy, then expects FFh data and a clear latch.

// File: rtl/spibk_pkg.sv
package spibk_pkg;
  localparam logic [7:0] OPC_STAT_WR = 8'h01;
  localparam logic [7:0] OPC_MEM_WR  = 8'h02;
  localparam logic [7:0] OPC_MEM_RD  = 8'h03;
  localparam logic [7:0] OPC_LATCH_C = 8'h04;
  localparam logic [7:0] OPC_STAT_RD = 8'h05;
  localparam logic [7:0] OPC_LATCH_S = 8'h06;
  localparam logic [7:0] OPC_MEM_WRH = 8'h0A;
  localparam logic [7:0] OPC_MEM_RDH = 8'h0B;
  localparam logic [7:0] OPC_IDENT   = 8'h9F;

  typedef enum logic [3:0] {
    PH_CMD, PH_ADR_HI, PH_ADR_LO, PH_RDAT, PH_WDAT,
    PH_STWR, PH_STAT, PH_FILL, PH_SKIP
  } phase_t;

  // top2: two most significant address bits of the array
  function automatic logic prot_hit(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'd1:    return top2 == 2'b11;
      2'd2:    return top2[1];
      2'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/spibk_pinsync.sv
module spibk_pinsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sel_start,
  output logic sel_end,
  output logic sel_act,
  output logic mosi_s
);
  logic [STAGES-1:0] sck_sr, cs_sr, dat_sr;
  logic sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sr <= '0;
      cs_sr  <= '1;
      dat_sr <= '0;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_sr <= {sck_sr[STAGES-2:0], sclk_i};
      cs_sr  <= {cs_sr[STAGES-2:0], cs_n_i};
      dat_sr <= {dat_sr[STAGES-2:0], mosi_i};
      sck_d  <= sck_sr[STAGES-1];
      cs_d   <= cs_sr[STAGES-1];
    end
  end

  assign sel_act   = !cs_sr[STAGES-1];
  assign sel_start = !cs_sr[STAGES-1] && cs_d;
  assign sel_end   = cs_sr[STAGES-1] && !cs_d;
  assign sclk_rise = sel_act && sck_sr[STAGES-1] && !sck_d;
  assign sclk_fall = sel_act && !sck_sr[STAGES-1] && sck_d;
  assign mosi_s    = dat_sr[STAGES-1];
endmodule

// File: rtl/spibk_shift.sv
module spibk_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       act,
  input  logic       rise,
  input  logic       fall,
  input  logic       mosi_s,
  input  logic       load,
  input  logic [7:0] load_val,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       aligned,
  output logic       miso
);
  logic [2:0] bitn;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr;

  assign byte_done = rise && (bitn == 3'd7);
  assign rx_byte   = {rx_sr, mosi_s};
  assign aligned   = (bitn == 3'd0);
  assign miso      = tx_sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitn  <= '0;
      rx_sr <= '0;
      tx_sr <= 8'hFF;
    end else if (start || !act) begin
      bitn  <= '0;
      tx_sr <= 8'hFF;
    end else begin
      if (rise) begin
        bitn  <= bitn + 3'd1;
        rx_sr <= {rx_sr[5:0], mosi_s};
      end
      if (load)
        tx_sr <= load_val;
      else if (fall && bitn != 3'd0)
        tx_sr <= {tx_sr[6:0], 1'b1};
    end
  end

  AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> byte_done); // R2
endmodule

// File: rtl/spibk_store.sv
module spibk_store
  import spibk_pkg::*;
#(
  parameter int MEM_BYTES  = 512,
  parameter int PAGE_BYTES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          stage_en,
  input  logic [7:0]                    stage_val,
  input  logic [$clog2(PAGE_BYTES)-1:0] stage_off,
  input  logic                          commit,
  input  logic [$clog2(MEM_BYTES)-1:0]  base,
  input  logic [1:0]                    bp,
  input  logic [$clog2(MEM_BYTES)-1:0]  rd_addr,
  output logic [7:0]                    rd_val,
  output logic                          staged_any
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  logic [7:0]            mem  [MEM_BYTES];
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvld;
  logic [AW-1:0]         slot_adr [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] slot_we;
  logic                  unused_base;

  assign unused_base = ^base[PW-1:0];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    assign slot_adr[g] = {base[AW-1:PW], PW'(g)};
    assign slot_we[g]  = pvld[g] && !prot_hit(bp, slot_adr[g][AW-1 -: 2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pvld <= '0;
    else if (clr)      pvld <= '0;
    else if (stage_en) pvld[stage_off] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (stage_en) pbuf[stage_off] <= stage_val;
  end

  always_ff @(posedge clk) begin
    if (commit)
      for (int i = 0; i < PAGE_BYTES; i++)
        if (slot_we[i]) mem[slot_adr[i]] <= pbuf[i];
  end

  assign rd_val     = mem[rd_addr];
  assign staged_any = |pvld;

  AST_COMMIT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> staged_any); // R6
  AST_STAGE_NOT_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !stage_en); // R6
endmodule

// File: rtl/spibk_target.sv
module spibk_target
  import spibk_pkg::*;
#(
  parameter bit ADDR9       = 1'b1,
  parameter int MEM_BYTES   = 512,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  logic sclk_rise, sclk_fall, sel_start, sel_end, sel_act, mosi_s;
  logic byte_done, aligned;
  logic [7:0] rx_byte;
  logic ld, st_en;
  logic [7:0] ld_val, rd_val, status_byte;
  logic staged_any, commit_mem, commit_sr, wip;

  phase_t        ph;
  logic          wel, lock, rd_mode, sr_pend, sr_lock;
  logic [1:0]    bp, sr_bp;
  logic [BW-1:0] busy_cnt;
  logic [7:0]    adr_hi;
  logic [AW-1:0] adr, wbase, rd_addr;
  logic [PW-1:0] woff;
  logic [15:0]   lo_full;
  logic          unused_hi;

  spibk_pinsync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sel_start(sel_start),
    .sel_end(sel_end), .sel_act(sel_act), .mosi_s(mosi_s)
  );

  spibk_shift u_shift (
    .clk(clk), .rst_n(rst_n), .start(sel_start), .act(sel_act),
    .rise(sclk_rise), .fall(sclk_fall), .mosi_s(mosi_s),
    .load(ld), .load_val(ld_val), .byte_done(byte_done), .rx_byte(rx_byte),
    .aligned(aligned), .miso(spi_miso)
  );

  spibk_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(sel_start), .stage_en(st_en), .stage_val(rx_byte),
    .stage_off(woff), .commit(commit_mem), .base(wbase), .bp(bp),
    .rd_addr(rd_addr), .rd_val(rd_val), .staged_any(staged_any)
  );

  assign wip       = (busy_cnt != '0);
  assign lo_full   = {adr_hi, rx_byte};
  assign unused_hi = ^{lo_full >> AW, lock};
  assign rd_addr   = (ph == PH_RDAT) ? adr : lo_full[AW-1:0];

  generate
    if (ADDR9) begin : g_st9
      assign status_byte = {4'hF, bp, wel, wip};
    end else begin : g_st16
      assign status_byte = {lock, 3'b000, bp, wel, wip};
    end
  endgenerate

  assign commit_mem = sel_end && aligned && wel && (ph == PH_WDAT) && staged_any;
  assign commit_sr  = sel_end && aligned && wel && sr_pend;

  // byte-boundary output selection and page staging
  always_comb begin
    ld     = 1'b0;
    ld_val = 8'hFF;
    st_en  = 1'b0;
    if (byte_done) begin
      case (ph)
        PH_CMD:    if (rx_byte == OPC_STAT_RD) begin ld = 1'b1; ld_val = status_byte; end
        PH_STAT:   begin ld = 1'b1; ld_val = status_byte; end
        PH_ADR_LO: if (rd_mode) begin ld = 1'b1; ld_val = rd_val; end
        PH_RDAT:   begin ld = 1'b1; ld_val = rd_val; end
        PH_WDAT:   st_en = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_CMD;
      wel      <= 1'b0;
      lock     <= 1'b0;
      bp       <= 2'b00;
      busy_cnt <= '0;
      rd_mode  <= 1'b0;
      sr_pend  <= 1'b0;
      sr_bp    <= 2'b00;
      sr_lock  <= 1'b0;
      adr_hi   <= '0;
      adr      <= '0;
      wbase    <= '0;
      woff     <= '0;
    end else begin
      if (wip) busy_cnt <= busy_cnt - 1'b1;
      if (sel_start) begin
        ph      <= PH_CMD;
        sr_pend <= 1'b0;
      end else if (sel_end) begin
        if (commit_mem || commit_sr) begin
          wel      <= 1'b0;
          busy_cnt <= BW'(BUSY_CYCLES);
        end
        if (commit_sr) begin
          bp <= sr_bp;
          if (!ADDR9) lock <= sr_lock;
        end
        ph      <= PH_CMD;
        sr_pend <= 1'b0;
      end else if (byte_done) begin
        case (ph)
          PH_CMD: begin
            if (wip && rx_byte != OPC_STAT_RD) begin
              ph <= PH_SKIP;
            end else begin
              case (rx_byte)
                OPC_LATCH_S: begin wel <= 1'b1; ph <= PH_SKIP; end
                OPC_LATCH_C: begin wel <= 1'b0; ph <= PH_SKIP; end
                OPC_STAT_RD: ph <= PH_STAT;
                OPC_STAT_WR: ph <= PH_STWR;
                OPC_IDENT:   ph <= PH_FILL;
                OPC_MEM_RD, OPC_MEM_WR, OPC_MEM_RDH, OPC_MEM_WRH: begin
                  if (ADDR9 || !rx_byte[3]) begin
                    rd_mode <= rx_byte[0];
                    adr_hi  <= ADDR9 ? {7'b0, rx_byte[3]} : 8'h00;
                    ph      <= ADDR9 ? PH_ADR_LO : PH_ADR_HI;
                  end else begin
                    ph <= PH_SKIP;
                  end
                end
                default: ph <= PH_SKIP;
              endcase
            end
          end
          PH_ADR_HI: begin
            adr_hi <= rx_byte;
            ph     <= PH_ADR_LO;
          end
          PH_ADR_LO: begin
            if (rd_mode) begin
              adr <= lo_full[AW-1:0] + AW'(1);
              ph  <= PH_RDAT;
            end else begin
              wbase <= lo_full[AW-1:0];
              woff  <= rx_byte[PW-1:0];
              ph    <= PH_WDAT;
            end
          end
          PH_RDAT: adr  <= adr + AW'(1);
          PH_WDAT: woff <= woff + PW'(1);
          PH_STWR: begin
            sr_bp   <= rx_byte[3:2];
            sr_lock <= rx_byte[7];
            sr_pend <= 1'b1;
            ph      <= PH_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  AST_LATCH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_mem || commit_sr) |=> !wel); // R9
  AST_BUSY_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_mem || commit_sr) |=> wip); // R9
  AST_COMMIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_mem || commit_sr) |-> !wip); // R10
  AST_BUSY_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ph == PH_CMD && wip && rx_byte != OPC_STAT_RD) |=> (ph == PH_SKIP)); // R10
  AST_LATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ph == PH_CMD && !wip && rx_byte == OPC_LATCH_S) |=> wel); // R2
endmodule

// File: tb/sim_spibk_target.sv
module sim_spibk_target;
  localparam int CLK_NS = 10;
  localparam int HALF   = 8;
  localparam int BUSY   = 300;

  // {address[8:0], data[7:0]} write-then-read vectors, 9-bit mode
  localparam logic [16:0] VEC [6] = '{
    {9'h000, 8'h3C}, {9'h0FF, 8'hC3}, {9'h100, 8'h5A},
    {9'h1FF, 8'hA5}, {9'h0A5, 8'h77}, {9'h17C, 8'h81}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, cs0_n = 1'b1, cs1_n = 1'b1;
  logic miso0, miso1;
  int n_run = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  spibk_target #(.ADDR9(1'b1), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs0_n),
    .spi_mosi(mosi), .spi_miso(miso0));
  spibk_target #(.ADDR9(1'b0), .BUSY_CYCLES(BUSY)) u1 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs1_n),
    .spi_mosi(mosi), .spi_miso(miso1));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic sel(input bit dev);
    @(negedge clk);
    if (dev) cs1_n = 1'b0; else cs0_n = 1'b0;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic desel(input bit dev);
    repeat (HALF) @(negedge clk);
    if (dev) cs1_n = 1'b1; else cs0_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic xfer(input bit dev, input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < nb; i++) begin
      mosi = tx[7-i];
      repeat (HALF) @(negedge clk);
      rx = {rx[6:0], dev ? miso1 : miso0};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic put(input bit dev, input logic [7:0] tx);
    logic [7:0] d;
    xfer(dev, tx, 8, d);
  endtask

  task automatic get(input bit dev, output logic [7:0] rx);
    xfer(dev, 8'hFF, 8, rx);
  endtask

  task automatic cmd1(input bit dev, input logic [7:0] op);
    sel(dev); put(dev, op); desel(dev);
  endtask

  task automatic rdsr(input bit dev, output logic [7:0] s);
    sel(dev); put(dev, 8'h05); get(dev, s); desel(dev);
  endtask

  task automatic settle();
    repeat (BUSY + 40) @(negedge clk);
  endtask

  task automatic wr9(input logic [8:0] a, input logic [7:0] d, input bit wait_busy);
    cmd1(1'b0, 8'h06);
    sel(1'b0); put(1'b0, a[8] ? 8'h0A : 8'h02); put(1'b0, a[7:0]); put(1'b0, d); desel(1'b0);
    if (wait_busy) settle();
  endtask

  task automatic rd9(input logic [8:0] a, output logic [7:0] d);
    sel(1'b0); put(1'b0, a[8] ? 8'h0B : 8'h03); put(1'b0, a[7:0]); get(1'b0, d); desel(1'b0);
  endtask

  task automatic wrsr(input bit dev, input logic [7:0] v);
    cmd1(dev, 8'h06);
    sel(dev); put(dev, 8'h01); put(dev, v); desel(dev);
    settle();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] s, s2, d, d2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    rdsr(1'b0, s); check("R1 status 9-bit", s, 8'hF0);
    rdsr(1'b1, s); check("R1 status 16-bit", s, 8'h00);

    // R2 latch and repeated status
    cmd1(1'b0, 8'h06);
    sel(1'b0); put(1'b0, 8'h05); get(1'b0, s); get(1'b0, s2); desel(1'b0);
    check("R2 latch set", s, 8'hF2); check("R2 status repeats", s2, 8'hF2);
    cmd1(1'b0, 8'h04);
    rdsr(1'b0, s); check("R2 latch cleared", s, 8'hF0);

    // R3 identification query
    sel(1'b0); put(1'b0, 8'h9F);
    for (int k = 0; k < 3; k++) begin get(1'b0, d); check("R3 ident byte", d, 8'hFF); end
    desel(1'b0);

    // R4 vector table walk
    for (int v = 0; v < 6; v++) begin
      wr9(VEC[v][16:8], VEC[v][7:0], 1'b1);
      rd9(VEC[v][16:8], d);
      check("R4 write/read", d, VEC[v][7:0]);
    end

    // R8 read wrap at end of array
    sel(1'b0); put(1'b0, 8'h0B); put(1'b0, 8'hFF); get(1'b0, d); get(1'b0, d2); desel(1'b0);
    check("R8 last byte", d, 8'hA5); check("R8 wrap to 0", d2, 8'h3C);

    // R6 no latch: ignored
    sel(1'b0); put(1'b0, 8'h02); put(1'b0, 8'hA5); put(1'b0, 8'h11); desel(1'b0);
    settle(); rd9(9'h0A5, d); check("R6 no latch", d, 8'h77);
    // R6 partial byte: ignored, latch kept
    cmd1(1'b0, 8'h06);
    sel(1'b0); put(1'b0, 8'h02); put(1'b0, 8'hA5); put(1'b0, 8'h11); xfer(1'b0, 8'h22, 4, d); desel(1'b0);
    settle(); rd9(9'h0A5, d); check("R6 partial byte", d, 8'h77);
    rdsr(1'b0, s); check("R6 latch kept", s, 8'hF2);
    cmd1(1'b0, 8'h04);

    // R7 page wrap
    cmd1(1'b0, 8'h06);
    sel(1'b0); put(1'b0, 8'h02); put(1'b0, 8'h2E);
    for (int k = 0; k < 18; k++) put(1'b0, 8'hD0 + 8'(k));
    desel(1'b0); settle();
    rd9(9'h020, d); check("R7 page start", d, 8'hD2);
    rd9(9'h02E, d); check("R7 overwrite", d, 8'hE0);
    rd9(9'h02F, d); check("R7 page end", d, 8'hE1);

    // R9 busy window visible in repeated status
    wr9(9'h040, 8'h99, 1'b0);
    sel(1'b0); put(1'b0, 8'h05); get(1'b0, s); get(1'b0, d); get(1'b0, s2); desel(1'b0);
    check("R9 busy after commit", s, 8'hF1); check("R9 idle after window", s2, 8'hF0);
    rd9(9'h040, d); check("R9 data", d, 8'h99);

    // R10 commands ignored while busy
    wr9(9'h041, 8'h55, 1'b0);
    sel(1'b0); put(1'b0, 8'h03); put(1'b0, 8'h41); get(1'b0, d); desel(1'b0);
    check("R10 read while busy", d, 8'hFF);
    settle();
    wr9(9'h042, 8'h66, 1'b0);
    cmd1(1'b0, 8'h06);
    settle();
    rdsr(1'b0, s); check("R10 latch-set ignored", s, 8'hF0);
    rd9(9'h041, d); check("R10 data", d, 8'h55);

    // R11 status write
    wrsr(1'b0, 8'hFF); rdsr(1'b0, s); check("R11 9-bit status write", s, 8'hFC);
    wrsr(1'b1, 8'hFF); rdsr(1'b1, s); check("R11 16-bit status write", s, 8'h8C);
    wrsr(1'b1, 8'h00); rdsr(1'b1, s); check("R11 16-bit clear", s, 8'h00);

    // R12 protection (u0 has field 3 now)
    wr9(9'h000, 8'hEE, 1'b1); rd9(9'h000, d); check("R12 all protected", d, 8'h3C);
    wrsr(1'b0, 8'h04);
    wr9(9'h1FF, 8'h11, 1'b1); rd9(9'h1FF, d); check("R12 quarter protected", d, 8'hA5);
    wr9(9'h17C, 8'h22, 1'b1); rd9(9'h17C, d); check("R12 below quarter", d, 8'h22);
    wrsr(1'b0, 8'h08);
    wr9(9'h100, 8'h33, 1'b1); rd9(9'h100, d); check("R12 half protected", d, 8'h5A);
    wr9(9'h0FF, 8'h44, 1'b1); rd9(9'h0FF, d); check("R12 below half", d, 8'h44);

    // R5 16-bit addressing
    cmd1(1'b1, 8'h06);
    sel(1'b1); put(1'b1, 8'h02); put(1'b1, 8'h01); put(1'b1, 8'h23);
    put(1'b1, 8'h5A); put(1'b1, 8'h5B); desel(1'b1);
    settle();
    sel(1'b1); put(1'b1, 8'h03); put(1'b1, 8'h01); put(1'b1, 8'h23);
    get(1'b1, d); get(1'b1, d2); desel(1'b1);
    check("R5 first byte", d, 8'h5A); check("R5 second byte", d2, 8'h5B);

    finish_run();
  end
endmodule